// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Interface

This block is the serial slave front end of a sigma-delta converter's register map. Each transfer opens with an eight-bit command that picks a register and a direction. The block then moves that register's bytes most significant bit first: it shifts them in on a write and out on a read. It holds the mode, configuration, general-purpose-output control, offset and full-scale registers. It also serves a read-only status byte, a read-only identity byte and the conversion result. The result word, the range and reference error flags and the channel number come from outside ports.

The serial clock idles high. The block samples input bits on rising clock edges and moves its output to the next bit just after each rising edge. All serial inputs are brought into the system clock domain through synchronisers. When no read is in progress, the data output doubles as a ready line: it is low while an unread result is waiting. In continuous-read mode, every new result is shifted out without a command. A run of consecutive one bits on the data input puts the whole interface back to its defaults.

Top module: `sd_serial_regif`

## Requirements
- R1: The command byte is decoded as follows. Bit 7 must be 0, bit 6 selects read (1) or write (0), bits 5:3 are the address and bit 2 requests continuous read. Bits 1:0 are ignored. A command with bit 7 set is dropped, has no data phase, and the next byte is taken as a new command.
- R2: Data phases are 8 bits for addresses 0, 4 and 5, and 24 bits for addresses 1, 2, 6 and 7, sent most significant bit first. Input is sampled on the rising serial clock edge. After the last data bit the next byte is a command.
- R3: Writes to address 1 (mode), 2 (configuration), 5 (general-purpose output, 8 bits), 6 (offset) and 7 (full scale) appear on the matching output port after the last data bit. Reading the same address returns the same value.
- R4: A write command to address 0 has no data phase. A write to address 3 consumes 24 bits and a write to address 4 consumes 8 bits, and neither changes any register.
- R5: The status byte has this layout: bit 7 not-ready, bit 6 range error input, bit 5 reference error input, bit 4 parity, bit 3 zero and bits 2:0 the channel input. Parity is the XOR of the 24 result bits when mode bit 13 is 1, and 0 otherwise.
- R6: Address 4 reads as {ID_UPPER, DEV_CODE}. The device identity sits in the low four bits.
- R7: A read of address 3 returns the 24-bit result. When mode bit 20 is 1 it returns 32 bits: the result followed by the status byte. The frame is captured when its first bit is presented.
- R8: The not-ready flag is 1 after reset and after the last bit of any address-3 read. A result strobe clears it, and the strobe wins when both happen in the same cycle. With chip select low and no read in progress, the data output shows the flag. With chip select high the data output is 1.
- R9: A read command to address 3 with bit 2 set enters continuous read with no data phase. While in continuous read and at a command boundary, each result strobe starts a data-register shift-out. All other commands are ignored, except a read of address 3 with bit 2 clear, which leaves continuous read and performs one normal data read.
- R10: 48 consecutive one bits sampled while chip select is low restore every register to its default, clear continuous read, set not-ready and return framing to the command byte.
- R11: Raising chip select aborts the current phase without a partial write, clears the run-of-ones count, and makes the next byte a command.
- R12: After reset the registers read mode 0x080060, configuration 0x000117, general-purpose output 0x00, offset 0x800000 and full scale 0x5A0000. Continuous read is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles high |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, doubles as not-ready |
| result_i | input | 24 | Conversion result word |
| result_stb_i | input | 1 | One-cycle pulse: new result available |
| range_err_i | input | 1 | Over/under-range flag |
| ref_err_i | input | 1 | Missing-reference flag |
| chan_i | input | 3 | Channel of the current result |
| mode_o | output | 24 | Mode register |
| conf_o | output | 24 | Configuration register |
| gpo_o | output | 8 | General-purpose-output control register |
| offset_o | output | 24 | Offset calibration register |
| fscale_o | output | 24 | Full-scale calibration register |
| cont_rd_o | output | 1 | Continuous-read mode active |

## Verification
A wrong bit count or a wrong phase shows as misframing. If that happens, the next command byte is taken as data and the readback of a known register in the following transfer comes out shifted or stale. So a framing slip is seen no later than one transfer after it happens. A corrupted register shows on its output port in the cycle after the last data bit. A stale not-ready flag shows on the data output within a few system clocks, with chip select low between transfers. A broken run-of-ones counter shows either as registers that fail to return to their defaults after 48 ones, or as registers that reset when chip select has split the run.

// File: rtl/sd_regif_pkg.sv
package sd_regif_pkg;

  localparam int RES_W   = 24;
  localparam int FRAME_W = 32;
  localparam int CNT_W   = 6;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CONF  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IDENT = 3'd4;
  localparam logic [ADDR_W-1:0] A_GPO   = 3'd5;
  localparam logic [ADDR_W-1:0] A_OFFS  = 3'd6;
  localparam logic [ADDR_W-1:0] A_FSCL  = 3'd7;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  // Bit length of the data phase that follows a command
  function automatic logic [CNT_W-1:0] frame_len(input logic [ADDR_W-1:0] a,
                                                 input logic rd,
                                                 input logic app);
    logic [CNT_W-1:0] n;
    case (a)
      A_STAT, A_IDENT, A_GPO: n = CNT_W'(8);
      A_DATA:                 n = (rd && app) ? CNT_W'(32) : CNT_W'(24);
      default:                n = CNT_W'(24);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sd_edge_sync.sv
module sd_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_n = {chain_q[STAGES-2:0], d};
    end else begin : g_single
      assign chain_n = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sd_ones_reset.sv
module sd_ones_reset #(
  parameter int RUN_LEN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic clear,
  output logic hit
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_n;

  always_comb begin
    run_n = run_q;
    hit   = 1'b0;
    if (clear) begin
      run_n = '0;
    end else if (bit_stb) begin
      if (!bit_val) begin
        run_n = '0;
      end else if (run_q == RUN_LAST) begin
        run_n = '0;
        hit   = 1'b1;
      end else begin
        run_n = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  // R10
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST);

  // R11
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> run_q == '0);
endmodule

// File: rtl/sd_regbank.sv
module sd_regbank
  import sd_regif_pkg::*;
#(
  parameter logic [RES_W-1:0] MODE_RST = 24'h080060,
  parameter logic [RES_W-1:0] CONF_RST = 24'h000117,
  parameter logic [7:0]       GPO_RST  = 8'h00,
  parameter logic [RES_W-1:0] OFFS_RST = 24'h800000,
  parameter logic [RES_W-1:0] FSCL_RST = 24'h5A0000,
  parameter logic [3:0]       ID_UPPER = 4'h8,
  parameter logic [3:0]       DEV_CODE = 4'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [RES_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]  rd_sel,
  input  logic [RES_W-1:0]   result,
  input  logic               nrdy,
  input  logic               range_err,
  input  logic               ref_err,
  input  logic [2:0]         chan,
  output logic [RES_W-1:0]   mode,
  output logic [RES_W-1:0]   conf,
  output logic [7:0]         gpo,
  output logic [RES_W-1:0]   offs,
  output logic [RES_W-1:0]   fscl,
  output logic [FRAME_W-1:0] rd_frame
);
  localparam int PAR_EN_BIT = 13;

  logic [RES_W-1:0] mode_n, conf_n, offs_n, fscl_n;
  logic [7:0]       gpo_n;
  logic             en_mode, en_conf, en_gpo, en_offs, en_fscl;
  logic [7:0]       status;
  logic             par;

  assign en_mode = we && (waddr == A_MODE);
  assign en_conf = we && (waddr == A_CONF);
  assign en_gpo  = we && (waddr == A_GPO);
  assign en_offs = we && (waddr == A_OFFS);
  assign en_fscl = we && (waddr == A_FSCL);

  always_comb begin
    mode_n = mode;
    conf_n = conf;
    gpo_n  = gpo;
    offs_n = offs;
    fscl_n = fscl;
    if (soft_rst) begin
      mode_n = MODE_RST;
      conf_n = CONF_RST;
      gpo_n  = GPO_RST;
      offs_n = OFFS_RST;
      fscl_n = FSCL_RST;
    end else begin
      if (en_mode) mode_n = wdata;
      if (en_conf) conf_n = wdata;
      if (en_gpo)  gpo_n  = wdata[7:0];
      if (en_offs) offs_n = wdata;
      if (en_fscl) fscl_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      conf <= CONF_RST;
      gpo  <= GPO_RST;
      offs <= OFFS_RST;
      fscl <= FSCL_RST;
    end else begin
      mode <= mode_n;
      conf <= conf_n;
      gpo  <= gpo_n;
      offs <= offs_n;
      fscl <= fscl_n;
    end
  end

  assign par    = mode[PAR_EN_BIT] & (^result);
  assign status = {nrdy, range_err, ref_err, par, 1'b0, chan};

  always_comb begin
    case (rd_sel)
      A_STAT:  rd_frame = {status, 24'h0};
      A_MODE:  rd_frame = {mode, 8'h0};
      A_CONF:  rd_frame = {conf, 8'h0};
      A_DATA:  rd_frame = {result, status};
      A_IDENT: rd_frame = {ID_UPPER, DEV_CODE, 24'h0};
      A_GPO:   rd_frame = {gpo, 24'h0};
      A_OFFS:  rd_frame = {offs, 8'h0};
      default: rd_frame = {fscl, 8'h0};
    endcase
  end

  // R4
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_rst && (waddr == A_STAT || waddr == A_DATA || waddr == A_IDENT))
    |=> ($stable(mode) && $stable(conf) && $stable(gpo) && $stable(offs) && $stable(fscl)));

  // R3
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_rst && waddr == A_MODE) |=> mode == $past(wdata));

  // R10
  soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode == MODE_RST && conf == CONF_RST && gpo == GPO_RST
                  && offs == OFFS_RST && fscl == FSCL_RST));
endmodule

// File: rtl/sd_serial_regif.sv
module sd_serial_regif
  import sd_regif_pkg::*;
#(
  parameter int               RESET_ONES  = 48,
  parameter int               SYNC_STAGES = 2,
  parameter logic [RES_W-1:0] MODE_RST    = 24'h080060,
  parameter logic [RES_W-1:0] CONF_RST    = 24'h000117,
  parameter logic [7:0]       GPO_RST     = 8'h00,
  parameter logic [RES_W-1:0] OFFS_RST    = 24'h800000,
  parameter logic [RES_W-1:0] FSCL_RST    = 24'h5A0000,
  parameter logic [3:0]       ID_UPPER    = 4'h8,
  parameter logic [3:0]       DEV_CODE    = 4'h4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        cs_n_i,
  input  logic        mosi_i,
  output logic        miso_o,
  input  logic [23:0] result_i,
  input  logic        result_stb_i,
  input  logic        range_err_i,
  input  logic        ref_err_i,
  input  logic [2:0]  chan_i,
  output logic [23:0] mode_o,
  output logic [23:0] conf_o,
  output logic [7:0]  gpo_o,
  output logic [23:0] offset_o,
  output logic [23:0] fscale_o,
  output logic        cont_rd_o
);
  localparam int APPEND_BIT = 20;
  localparam int CMD_KEEP   = 6;
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(7);

  logic rst_ns;
  logic sck_s, cs_n_s, mosi_s, sck_d;
  logic sck_rise, soft_rst;

  // synchronous release of the asynchronous reset
  sd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns));

  sd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_ns), .d(sck_i), .q(sck_s));
  sd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_ns), .d(cs_n_i), .q(cs_n_s));
  sd_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi_sync (
    .clk(clk), .rst_n(rst_ns), .d(mosi_i), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) sck_d <= 1'b1;
    else         sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d & ~cs_n_s;

  sd_ones_reset #(.RUN_LEN(RESET_ONES)) u_ones (
    .clk(clk), .rst_n(rst_ns), .bit_stb(sck_rise), .bit_val(mosi_s),
    .clear(cs_n_s), .hit(soft_rst));

  phase_e             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n, len_q, len_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [CMD_KEEP-1:0] cmd_q, cmd_n;
  logic [RES_W-2:0]   win_q, win_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               cread_q, cread_n, nrdy_q, nrdy_n;
  logic               we, nrdy_eff;
  logic [ADDR_W-1:0]  rd_sel;
  logic [FRAME_W-1:0] rd_frame;
  logic [RES_W-1:0]   mode_w, wdata;

  // kept command fields: [5]=bit7 [4]=bit6 [3:1]=addr [0]=bit2
  logic               c_inval, c_rd, c_cont;
  logic [ADDR_W-1:0]  c_addr;
  assign c_inval = cmd_q[5];
  assign c_rd    = cmd_q[4];
  assign c_addr  = cmd_q[3:1];
  assign c_cont  = cmd_q[0];

  assign nrdy_eff = nrdy_q & ~result_stb_i;
  assign rd_sel   = cread_q ? A_DATA : c_addr;
  assign wdata    = {win_q, mosi_s};

  sd_regbank #(
    .MODE_RST(MODE_RST), .CONF_RST(CONF_RST), .GPO_RST(GPO_RST),
    .OFFS_RST(OFFS_RST), .FSCL_RST(FSCL_RST),
    .ID_UPPER(ID_UPPER), .DEV_CODE(DEV_CODE)
  ) u_bank (
    .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst),
    .we(we), .waddr(addr_q), .wdata(wdata), .rd_sel(rd_sel),
    .result(result_i), .nrdy(nrdy_eff), .range_err(range_err_i),
    .ref_err(ref_err_i), .chan(chan_i),
    .mode(mode_w), .conf(conf_o), .gpo(gpo_o), .offs(offset_o),
    .fscl(fscale_o), .rd_frame(rd_frame));

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    addr_n  = addr_q;
    cmd_n   = cmd_q;
    win_n   = win_q;
    sh_n    = sh_q;
    cread_n = cread_q;
    nrdy_n  = nrdy_q;
    we      = 1'b0;
    if (cs_n_s) begin
      phase_n = PH_CMD;
      cnt_n   = '0;
    end else begin
      case (phase_q)
        PH_CMD: begin
          if (cread_q && cnt_q == '0 && result_stb_i) begin
            phase_n = PH_RD;
            cnt_n   = '0;
            addr_n  = A_DATA;
            len_n   = frame_len(A_DATA, 1'b1, mode_w[APPEND_BIT]);
            sh_n    = rd_frame;
          end else if (sck_rise) begin
            if (cnt_q < CNT_W'(CMD_KEEP)) cmd_n = {cmd_q[CMD_KEEP-2:0], mosi_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CMD_LAST) begin
              cnt_n = '0;
              if (!c_inval) begin
                if (cread_q) begin
                  if (c_rd && c_addr == A_DATA && !c_cont) begin
                    cread_n = 1'b0;
                    phase_n = PH_RD;
                    addr_n  = A_DATA;
                    len_n   = frame_len(A_DATA, 1'b1, mode_w[APPEND_BIT]);
                    sh_n    = rd_frame;
                  end
                end else if (c_rd) begin
                  if (c_addr == A_DATA && c_cont) begin
                    cread_n = 1'b1;
                  end else begin
                    phase_n = PH_RD;
                    addr_n  = c_addr;
                    len_n   = frame_len(c_addr, 1'b1, mode_w[APPEND_BIT]);
                    sh_n    = rd_frame;
                  end
                end else if (c_addr != A_STAT) begin
                  phase_n = PH_WR;
                  addr_n  = c_addr;
                  len_n   = frame_len(c_addr, 1'b0, 1'b0);
                end
              end
            end
          end
        end
        PH_RD: begin
          if (sck_rise) begin
            sh_n  = {sh_q[FRAME_W-2:0], 1'b0};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) begin
              phase_n = PH_CMD;
              cnt_n   = '0;
              if (addr_q == A_DATA) nrdy_n = 1'b1;
            end
          end
        end
        default: begin
          if (sck_rise) begin
            win_n = {win_q[RES_W-3:0], mosi_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) begin
              we      = 1'b1;
              phase_n = PH_CMD;
              cnt_n   = '0;
            end
          end
        end
      endcase
    end
    if (result_stb_i) nrdy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      win_q   <= '0;
      sh_q    <= '0;
      cread_q <= 1'b0;
      nrdy_q  <= 1'b1;
    end else if (soft_rst) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      win_q   <= '0;
      sh_q    <= '0;
      cread_q <= 1'b0;
      nrdy_q  <= 1'b1;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      addr_q  <= addr_n;
      cmd_q   <= cmd_n;
      win_q   <= win_n;
      sh_q    <= sh_n;
      cread_q <= cread_n;
      nrdy_q  <= nrdy_n;
    end
  end

  assign miso_o    = cs_n_s ? 1'b1 : ((phase_q == PH_RD) ? sh_q[FRAME_W-1] : nrdy_q);
  assign mode_o    = mode_w;
  assign cont_rd_o = cread_q;

  // R2
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q != PH_CMD) |-> (cnt_q < len_q));

  // R7
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_RD && addr_q == A_DATA)
    |-> (len_q == (mode_w[APPEND_BIT] ? CNT_W'(32) : CNT_W'(24))));

  // R9
  cread_entry_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(cread_q) |-> (phase_q == PH_CMD && cnt_q == '0));

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (result_stb_i && !soft_rst) |=> !nrdy_q);

  // R11
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n_s |=> (phase_q == PH_CMD && cnt_q == '0));
endmodule

// File: tb/tb_sd_serial_regif.sv
module tb_sd_serial_regif;
  localparam int HALF = 6;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi, miso;
  logic [23:0] result;
  logic stb, range_err, ref_err;
  logic [2:0] chan;
  logic [23:0] mode_o, conf_o, offset_o, fscale_o;
  logic [7:0] gpo_o;
  logic cont_rd;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sd_serial_regif dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .result_i(result), .result_stb_i(stb),
    .range_err_i(range_err), .ref_err_i(ref_err), .chan_i(chan),
    .mode_o(mode_o), .conf_o(conf_o), .gpo_o(gpo_o), .offset_o(offset_o),
    .fscale_o(fscale_o), .cont_rd_o(cont_rd));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sck = 1'b0;
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic rd_bytes(input int n, output logic [31:0] val);
    logic [7:0] b;
    val = '0;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, b);
      val = {val[23:0], b};
    end
  endtask

  task automatic wr24(input logic [7:0] cmd, input logic [23:0] v);
    send(cmd);
    send(v[23:16]);
    send(v[15:8]);
    send(v[7:0]);
  endtask

  task automatic cs_cycle();
    @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_result(input logic [23:0] v);
    @(negedge clk);
    result = v;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] stat_byte(input logic nr, input logic [23:0] r, input logic pen);
    return {nr, range_err, ref_err, pen & (^r), 1'b0, chan};
  endfunction

  task automatic t_reset_state();
    check("R12 mode default", {8'h0, mode_o}, 32'h080060);
    check("R12 conf default", {8'h0, conf_o}, 32'h000117);
    check("R12 gpo default", {24'h0, gpo_o}, 32'h0);
    check("R12 offset default", {8'h0, offset_o}, 32'h800000);
    check("R12 fscale default", {8'h0, fscale_o}, 32'h5A0000);
    check("R12 cread off", {31'h0, cont_rd}, 32'h0);
    check("R8 miso high with cs high", {31'h0, miso}, 32'h1);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 miso shows not-ready", {31'h0, miso}, 32'h1);
    send(8'h60);
    rd_bytes(1, v);
    check("R6 R2 ident read", v, 32'h84);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr24(8'h08, 24'h0A1B2C);
    check("R3 mode port", {8'h0, mode_o}, 32'h0A1B2C);
    send(8'h48); rd_bytes(3, v);
    check("R3 mode readback", v, 32'h0A1B2C);
    wr24(8'h10, 24'h3C5A96);
    check("R3 conf port", {8'h0, conf_o}, 32'h3C5A96);
    send(8'h50); rd_bytes(3, v);
    check("R3 conf readback", v, 32'h3C5A96);
    send(8'h28); send(8'h5D);
    check("R3 gpo port", {24'h0, gpo_o}, 32'h5D);
    send(8'h68); rd_bytes(1, v);
    check("R2 R3 gpo 8-bit readback", v, 32'h5D);
    wr24(8'h30, 24'h7E8123);
    send(8'h70); rd_bytes(3, v);
    check("R3 offset readback", v, 32'h7E8123);
    wr24(8'h38, 24'h24C3E1);
    send(8'h78); rd_bytes(3, v);
    check("R3 fscale readback", v, 32'h24C3E1);
    check("R3 fscale port", {8'h0, fscale_o}, 32'h24C3E1);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    send(8'h20); send(8'hAA);
    wr24(8'h18, 24'h112233);
    send(8'h00);
    send(8'h68); rd_bytes(1, v);
    check("R4 framing after read-only writes", v, 32'h5D);
    check("R4 mode untouched", {8'h0, mode_o}, 32'h0A1B2C);
    check("R4 offset untouched", {8'h0, offset_o}, 32'h7E8123);
    send(8'h60); rd_bytes(1, v);
    check("R4 ident unchanged", v, 32'h84);
  endtask

  task automatic t_invalid_cmd();
    logic [31:0] v;
    send(8'h88);
    send(8'h68); rd_bytes(1, v);
    check("R1 bit7 command ignored", v, 32'h5D);
    check("R1 mode kept", {8'h0, mode_o}, 32'h0A1B2C);
  endtask

  task automatic t_status_and_data();
    logic [31:0] v;
    range_err = 1'b1; ref_err = 1'b0; chan = 3'd5;
    repeat (4) @(negedge clk);
    send(8'h40); rd_bytes(1, v);
    check("R5 status not ready", v, 32'hC5);
    pulse_result(24'h5A5A5A);
    check("R8 miso low when ready", {31'h0, miso}, 32'h0);
    send(8'h40); rd_bytes(1, v);
    check("R5 status ready", v, 32'h45);
    send(8'h58); rd_bytes(3, v);
    check("R7 24-bit data read", v, 32'h5A5A5A);
    repeat (4) @(negedge clk);
    check("R8 not-ready after data read", {31'h0, miso}, 32'h1);
  endtask

  task automatic t_append();
    logic [31:0] v;
    wr24(8'h08, 24'h1020A5);
    ref_err = 1'b1;
    pulse_result(24'h3C0F80);
    send(8'h58); rd_bytes(4, v);
    check("R7 R5 32-bit data with status and parity", v,
          {24'h3C0F80, stat_byte(1'b0, 24'h3C0F80, 1'b1)});
  endtask

  task automatic t_cread();
    logic [31:0] v;
    send(8'h5C);
    check("R9 cread entered", {31'h0, cont_rd}, 32'h1);
    check("R9 no data phase, still not ready", {31'h0, miso}, 32'h1);
    pulse_result(24'hABCDEF);
    rd_bytes(4, v);
    check("R9 first cread frame", v, {24'hABCDEF, stat_byte(1'b0, 24'hABCDEF, 1'b1)});
    repeat (4) @(negedge clk);
    check("R8 not ready after cread frame", {31'h0, miso}, 32'h1);
    pulse_result(24'h123456);
    rd_bytes(4, v);
    check("R9 second cread frame", v, {24'h123456, stat_byte(1'b0, 24'h123456, 1'b1)});
    send(8'h60);
    check("R9 other command ignored", {31'h0, cont_rd}, 32'h1);
    send(8'h58);
    check("R9 cread left", {31'h0, cont_rd}, 32'h0);
    rd_bytes(4, v);
    check("R9 exit performs data read", v, {24'h123456, stat_byte(1'b1, 24'h123456, 1'b1)});
  endtask

  task automatic t_abort();
    logic [31:0] v;
    send(8'h08); send(8'hFF);
    @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 miso high with cs high", {31'h0, miso}, 32'h1);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    send(8'h48); rd_bytes(3, v);
    check("R11 no partial write", v, 32'h1020A5);
  endtask

  task automatic t_ones();
    logic [31:0] v;
    cs_cycle();
    for (int i = 0; i < 5; i++) send(8'hFF);
    cs_cycle();
    send(8'hFF);
    check("R11 split run does not reset", {8'h0, mode_o}, 32'h1020A5);
    cs_cycle();
    send(8'h5C);
    check("R10 cread before reset", {31'h0, cont_rd}, 32'h1);
    for (int i = 0; i < 6; i++) send(8'hFF);
    repeat (4) @(negedge clk);
    check("R10 mode default", {8'h0, mode_o}, 32'h080060);
    check("R10 conf default", {8'h0, conf_o}, 32'h000117);
    check("R10 gpo default", {24'h0, gpo_o}, 32'h0);
    check("R10 offset default", {8'h0, offset_o}, 32'h800000);
    check("R10 fscale default", {8'h0, fscale_o}, 32'h5A0000);
    check("R10 cread cleared", {31'h0, cont_rd}, 32'h0);
    check("R10 not ready", {31'h0, miso}, 32'h1);
    send(8'h60); rd_bytes(1, v);
    check("R10 framing after reset", v, 32'h84);
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b1; cs_n = 1'b1; mosi = 1'b0;
    result = '0; stb = 1'b0; range_err = 1'b0; ref_err = 1'b0; chan = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset_state();
    t_ident();
    t_regs();
    t_readonly();
    t_invalid_cmd();
    t_status_and_data();
    t_append();
    t_cread();
    t_abort();
    t_ones();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule